// File: doc/BRIEF.md
# Up/Down Event Counter with Preset Compare

The block counts single-cycle event pulses up or down according to a direction input and holds a programmable preset. It compares the count with the preset as signed numbers. It drives a status byte that reports the current direction, equality with the preset, and whether the count is above the preset. Three interrupt sources are available, each with its own enable: the count arriving at the preset, a rising edge of the external clear input, and a change in counting direction. Each interrupt is a one-cycle pulse.

Setup goes through a small write port. A "define" write sets the count enable and the three interrupt enables. Only one define is accepted in each run session. Any later define leaves the setup as it is and sets a sticky error flag. A new run session starts on a rising edge of the run-mode input, which clears both the lock and the flag. The preset and the count can be written at any time.

Top module: `evt_counter`

## Requirements
- R1: Status bits 4..0 are always 0. Bit 5 holds the direction input registered at the previous clock edge (1 = up, 0 = down).
- R2: Status bit 6 is 1 exactly when the count equals the preset.
- R3: Status bit 7 is 1 exactly when the count, taken as signed 32-bit, is greater than the preset taken as signed 32-bit.
- R4: At a clock edge with `cnt_pulse` high and counting enabled, the count increments when `dir_in`=1 and decrements when `dir_in`=0, wrapping modulo 2^32. When counting is disabled the count does not change.
- R5: `ext_clr` high at a clock edge clears the count to 0. This takes priority over a count load and over a count pulse.
- R6: `irq_match` pulses for one cycle when status bit 6 goes from 0 to 1 and define bit 0 is set.
- R7: `irq_clr` pulses for one cycle after `ext_clr` is first sampled high, if define bit 1 is set.
- R8: `irq_dir` pulses for one cycle whenever status bit 5 changes value, if define bit 2 is set.
- R9: A define write (`wr_sel`=0) made while `run_mode` is high and no define has yet been taken in this session loads the setup from `wr_data[3:0]` (bit 0 match irq enable, bit 1 clear irq enable, bit 2 direction irq enable, bit 3 count enable) and locks. A later define in the same session sets `def_err` and leaves the setup unchanged. A define made while `run_mode` is low has no effect.
- R10: A rising edge of `run_mode` clears the lock and `def_err`.
- R11: `wr_sel`=1 loads the preset and `wr_sel`=2 loads the count, both at any time. `wr_sel`=3 is ignored.
- R12: After reset the count and preset are 0, the direction is up, the status byte is 0x60, no interrupt is raised, `def_err` is 0, and counting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_mode | input | 1 | High while in run mode; a rising edge starts a session |
| cnt_pulse | input | 1 | Count event, one per cycle when high |
| dir_in | input | 1 | Counting direction, 1 = up |
| ext_clr | input | 1 | External clear of the count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 define, 1 preset, 2 count load, 3 none |
| wr_data | input | 32 | Write data |
| count | output | 32 | Current count |
| status | output | 8 | {above preset, equal, direction, 5'b0} |
| irq_match | output | 1 | Count reached preset pulse |
| irq_clr | output | 1 | External clear pulse |
| irq_dir | output | 1 | Direction change pulse |
| def_err | output | 1 | Repeated define in this session |

## Verification
The assertions assume that every input is synchronous to `clk` and that a define write never falls in the same cycle as the rising edge of `run_mode`. In that cycle the session restart wins and the define is not judged. The stimulus changes inputs only on the falling clock edge. It always leaves at least one idle cycle after raising `run_mode` before it issues a define, so both assumptions hold across the vector table and the directed cases.

// File: rtl/evtc_pkg.sv
// Package: shared types and constants for the event counter.
// Assumes: the status byte is always 8 bits wide.
package evtc_pkg;

    localparam int CFG_W  = 4;
    localparam int STAT_W = 8;
    localparam int IRQ_N  = 3;

    // Status byte bit positions (read by software, so fixed)
    localparam int ST_DIR = 5;
    localparam int ST_EQ  = 6;
    localparam int ST_GT  = 7;

    // Interrupt source index
    localparam int IRQ_MATCH = 0;
    localparam int IRQ_CLR   = 1;
    localparam int IRQ_DIR   = 2;

    // Write selector encoding
    typedef enum logic [1:0] {
        SEL_DEFINE = 2'd0,
        SEL_PRESET = 2'd1,
        SEL_LOAD   = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    // Setup word; eq_ie lands on bit 0
    typedef struct packed {
        logic cnt_en;
        logic dir_ie;
        logic clr_ie;
        logic eq_ie;
    } cfg_t;

endpackage

// File: rtl/evtc_setup_lock.sv
// Module: evtc_setup_lock
// Holds the setup word, which is taken once per run session, and reports
// repeated define attempts.
// Assumes: def_we is a one-cycle strobe synchronous to clk.
module evtc_setup_lock
    import evtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_mode,
    input  logic             def_we,
    input  logic [CFG_W-1:0] def_data,
    output cfg_t             cfg,
    output logic             def_err
);

    logic run_q;
    logic run_rise;
    logic locked;

    // Purpose: remember run_mode to find the start of a session
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_mode;
    end

    assign run_rise = run_mode & ~run_q;

    // Purpose: accept the first define of a session, flag any repeat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            locked  <= 1'b0;
            def_err <= 1'b0;
        end else if (run_rise) begin
            locked  <= 1'b0;
            def_err <= 1'b0;
        end else if (def_we && run_mode) begin
            if (!locked) begin
                cfg    <= cfg_t'(def_data);
                locked <= 1'b1;
            end else begin
                def_err <= 1'b1;
            end
        end
    end

    AST_REPEAT_KEEPS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && def_we && run_mode && !run_rise) |=> (cfg == $past(cfg)) && def_err); // R9

    AST_FIRST_DEFINE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && def_we && run_mode && !run_rise) |=> locked && (cfg == $past(def_data))); // R9

    AST_SESSION_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        run_rise |=> !def_err && !locked); // R10

endmodule

// File: rtl/evtc_count_core.sv
// Module: evtc_count_core
// Holds the up/down count, the preset register and the registered direction.
// Assumes: at most one count event per clock; ext_clr is synchronous.
module evtc_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_pulse,
    input  logic             dir_in,
    input  logic             ext_clr,
    input  logic             load_we,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] preset,
    output logic             dir_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    assign step = cnt_en & cnt_pulse;

    // Purpose: update the count; clear wins over load, load wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (ext_clr) count <= '0;
        else if (load_we) count <= wr_data;
        else if (step)    count <= dir_in ? count + ONE : count - ONE;
    end

    // Purpose: hold the compare value
    always_ff @(posedge clk) begin
        if (!rst_n)         preset <= '0;
        else if (preset_we) preset <= wr_data;
    end

    // Purpose: register the direction for the status byte
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b1;
        else        dir_q <= dir_in;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |=> (count == '0)); // R5

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dir_in && !ext_clr && !load_we) |=> (count == $past(count) + ONE)); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dir_in && !ext_clr && !load_we) |=> (count == $past(count) - ONE)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ext_clr && !load_we) |=> $stable(count)); // R4

endmodule

// File: rtl/evtc_status_irq.sv
// Module: evtc_status_irq
// Builds the status byte from the signed compare and raises one-cycle
// interrupt pulses on preset match, external clear edge and direction change.
// Assumes: count, preset and dir_q come straight from registers.
module evtc_status_irq
    import evtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  preset,
    input  logic              dir_q,
    input  logic              ext_clr,
    input  cfg_t              cfg,
    output logic [STAT_W-1:0] status,
    output logic [IRQ_N-1:0]  irq
);

    // 1 = pulse on any change, 0 = pulse on a rising level
    localparam logic [IRQ_N-1:0] ANY_EDGE = 3'b100;
    // Level values at reset: equal, clear low, direction up
    localparam logic [IRQ_N-1:0] PREV_RST = 3'b101;

    logic             eq;
    logic             gt;
    logic             clr_q;
    logic [IRQ_N-1:0] lvl;
    logic [IRQ_N-1:0] prev;
    logic [IRQ_N-1:0] ie;

    assign eq = (count == preset);
    assign gt = $signed(count) > $signed(preset);

    // Purpose: pack the status byte; the low bits are unused
    always_comb begin
        status         = '0;
        status[ST_DIR] = dir_q;
        status[ST_EQ]  = eq;
        status[ST_GT]  = gt;
    end

    // Purpose: register the external clear for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= ext_clr;
    end

    assign lvl = {dir_q, clr_q, eq};
    assign ie  = {cfg.dir_ie, cfg.clr_ie, cfg.eq_ie};

    // Purpose: keep each source level one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= PREV_RST;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        if (ANY_EDGE[i]) begin : g_any
            assign irq[i] = ie[i] & (lvl[i] ^ prev[i]);
        end else begin : g_rise
            assign irq[i] = ie[i] & lvl[i] & ~prev[i];
        end
    end

    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[IRQ_MATCH] |=> !irq[IRQ_MATCH]); // R6

    AST_MATCH_NEEDS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq[IRQ_MATCH] |-> (count == preset)); // R6

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[IRQ_CLR] |=> !irq[IRQ_CLR]); // R7

    AST_CLR_SEES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[IRQ_CLR] |-> (count == '0)); // R7

    AST_GT_EQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_GT] && status[ST_EQ])); // R3

endmodule

// File: rtl/evt_counter.sv
// Module: evt_counter (top)
// Up/down event counter with a signed preset compare, status byte,
// three gated interrupt pulses and a once-per-session setup lock.
// Assumes: all inputs are synchronous to clk.
module evt_counter
    import evtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_mode,
    input  logic              cnt_pulse,
    input  logic              dir_in,
    input  logic              ext_clr,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic [STAT_W-1:0] status,
    output logic              irq_match,
    output logic              irq_clr,
    output logic              irq_dir,
    output logic              def_err
);

    cfg_t             cfg;
    logic [CNT_W-1:0] preset;
    logic             dir_q;
    logic [IRQ_N-1:0] irq;
    logic             def_we;
    logic             preset_we;
    logic             load_we;

    assign def_we    = wr_en && (wr_sel == SEL_DEFINE);
    assign preset_we = wr_en && (wr_sel == SEL_PRESET);
    assign load_we   = wr_en && (wr_sel == SEL_LOAD);

    evtc_setup_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_mode (run_mode),
        .def_we   (def_we),
        .def_data (wr_data[CFG_W-1:0]),
        .cfg      (cfg),
        .def_err  (def_err)
    );

    evtc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cfg.cnt_en),
        .cnt_pulse (cnt_pulse),
        .dir_in    (dir_in),
        .ext_clr   (ext_clr),
        .load_we   (load_we),
        .preset_we (preset_we),
        .wr_data   (wr_data),
        .count     (count),
        .preset    (preset),
        .dir_q     (dir_q)
    );

    evtc_status_irq #(.CNT_W(CNT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .preset  (preset),
        .dir_q   (dir_q),
        .ext_clr (ext_clr),
        .cfg     (cfg),
        .status  (status),
        .irq     (irq)
    );

    assign irq_match = irq[IRQ_MATCH];
    assign irq_clr   = irq[IRQ_CLR];
    assign irq_dir   = irq[IRQ_DIR];

    AST_IGNORED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE && !ext_clr && !cnt_pulse) |=> $stable(count)); // R11

endmodule

// File: tb/evt_counter_tb.sv
`timescale 1ns/1ps
module evt_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_mode = 1'b0;
    logic        cnt_pulse = 1'b0;
    logic        dir_in = 1'b1;
    logic        ext_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;
    logic [7:0]  status;
    logic        irq_match, irq_clr, irq_dir, def_err;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    evt_counter u_dut (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .cnt_pulse(cnt_pulse),
        .dir_in(dir_in), .ext_clr(ext_clr), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .status(status), .irq_match(irq_match),
        .irq_clr(irq_clr), .irq_dir(irq_dir), .def_err(def_err)
    );

    // Vector: {pulse, dir, clr, exp_count[31:0], exp_status[7:0], exp_irq{dir,clr,match}}
    localparam int NV = 12;
    localparam logic [45:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 32'h0000_0001, 8'h20, 3'b000},
        {1'b1, 1'b1, 1'b0, 32'h0000_0002, 8'h20, 3'b000},
        {1'b1, 1'b1, 1'b0, 32'h0000_0003, 8'h60, 3'b001},
        {1'b0, 1'b1, 1'b0, 32'h0000_0003, 8'h60, 3'b000},
        {1'b1, 1'b1, 1'b0, 32'h0000_0004, 8'hA0, 3'b000},
        {1'b0, 1'b0, 1'b0, 32'h0000_0004, 8'h80, 3'b100},
        {1'b1, 1'b0, 1'b0, 32'h0000_0003, 8'h40, 3'b001},
        {1'b1, 1'b0, 1'b0, 32'h0000_0002, 8'h00, 3'b000},
        {1'b1, 1'b0, 1'b1, 32'h0000_0000, 8'h00, 3'b010},
        {1'b0, 1'b0, 1'b1, 32'h0000_0000, 8'h00, 3'b000},
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 8'h00, 3'b000},
        {1'b1, 1'b1, 1'b0, 32'h0000_0000, 8'h20, 3'b100}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic p, input logic d, input logic c);
        cnt_pulse = p; dir_in = d; ext_clr = c;
        tick();
        cnt_pulse = 1'b0; ext_clr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state, sampled while reset is held
        chk(count == 0, "R12 count", count, 0);
        chk(status == 8'h60, "R12 status", {24'h0, status}, 32'h60);
        chk({irq_dir, irq_clr, irq_match, def_err} == 0, "R12 irq/err",
            {28'h0, irq_dir, irq_clr, irq_match, def_err}, 0);
        rst_n = 1'b1;
        run_mode = 1'b1;
        tick();
        tick();
        // R4 counting disabled before any define
        step(1'b1, 1'b1, 1'b0);
        chk(count == 0, "R4 disabled", count, 0);
        wr(2'd1, 32'd3);
        wr(2'd0, 32'hF);
        chk(def_err == 1'b0, "R9 first define", {31'h0, def_err}, 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][45], VEC[i][44], VEC[i][43]);
            chk(count == VEC[i][42:11], $sformatf("R4/R5 count vec %0d", i), count, VEC[i][42:11]);
            chk(status == VEC[i][10:3], $sformatf("R1/R2/R3 status vec %0d", i),
                {24'h0, status}, {24'h0, VEC[i][10:3]});
            chk({irq_dir, irq_clr, irq_match} == VEC[i][2:0], $sformatf("R6/R7/R8 irq vec %0d", i),
                {29'h0, irq_dir, irq_clr, irq_match}, {29'h0, VEC[i][2:0]});
        end

        // R9 repeated define: error set, setup kept (still counting)
        wr(2'd0, 32'h0);
        chk(def_err == 1'b1, "R9 repeat error", {31'h0, def_err}, 1);
        step(1'b1, 1'b1, 1'b0);
        chk(count == 1, "R9 setup kept", count, 1);

        // R11 ignored select
        wr(2'd3, 32'h55);
        chk(count == 1 && status == 8'h20, "R11 sel3 ignored", {status, count[23:0]}, {8'h20, 24'h1});

        // R3 signed compare and R11 loads
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'd5);
        chk(count == 5, "R11 load", count, 5);
        chk(status == 8'hA0, "R3 5 > -16", {24'h0, status}, 32'hA0);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h7FFF_FFFF);
        chk(status == 8'hA0, "R3 max positive", {24'h0, status}, 32'hA0);
        step(1'b1, 1'b1, 1'b0);
        chk(count == 32'h8000_0000 && status == 8'h20, "R3 wrap to negative",
            count, 32'h8000_0000);
        wr(2'd2, 32'hFFFF_FFFF);
        step(1'b1, 1'b1, 1'b0);
        chk(count == 0, "R4 wrap to zero", count, 0);
        chk(irq_match == 1'b1, "R6 match after wrap", {31'h0, irq_match}, 1);

        // R10 new session clears the error and reopens define
        run_mode = 1'b0;
        tick();
        run_mode = 1'b1;
        tick();
        chk(def_err == 1'b0, "R10 error cleared", {31'h0, def_err}, 0);
        tick();
        wr(2'd0, 32'h8);
        chk(def_err == 1'b0, "R10 define reopened", {31'h0, def_err}, 0);
        wr(2'd1, 32'd2);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        chk(status == 8'h60, "R2 equal", {24'h0, status}, 32'h60);
        chk(irq_match == 1'b0, "R6 disabled", {31'h0, irq_match}, 0);
        step(1'b0, 1'b0, 1'b1);
        chk(irq_clr == 1'b0, "R7 disabled", {31'h0, irq_clr}, 0);
        chk(irq_dir == 1'b0, "R8 disabled", {31'h0, irq_dir}, 0);
        chk(count == 0 && status == 8'h00, "R5 clear", count, 0);

        // R9 define with run_mode low is ignored
        run_mode = 1'b0;
        tick();
        wr(2'd0, 32'h0);
        chk(def_err == 1'b0, "R9 define outside run", {31'h0, def_err}, 0);
        step(1'b1, 1'b1, 1'b0);
        chk(count == 1, "R9 setup unchanged outside run", count, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule